// File: doc/BRIEF.md
# Prescaled Delay-Width Pulse Generator

This block is one output channel of a timing receiver. A decoded trigger strobe starts a pulse that turns on after a programmed delay and stays on for a programmed width. Both the delay and the width are counted in ticks of a local prescaler, which divides the event clock by a programmable ratio. A synchronous strobe shared by all channels returns the prescaler to a known phase, so that every channel on the chip ticks in step after it.

Two further decoded strobes, set and clear, drive the output level directly and do not pass through the delay path. Clear also stops any pulse that is running. A polarity bit inverts the output pin. An enable bit makes the block deaf to trigger, set and clear. The prescaler keeps running while the block is disabled, and a pulse that is already running also keeps running.

All inputs are plain control levels sampled on the clock. The block has no data stream, so it has no valid/ready handshake and never applies back-pressure. A strobe is acted on in the cycle in which it is high, or it is dropped under the rules below.

Top module: `dly_wid_pulse_gen`

## Requirements
- R1: After reset the internal level is inactive, no pulse is pending and the prescaler count is zero. With polarity 0, `pulse_o` is 0.
- R2: A prescaler ratio P of 2 or more gives one tick every P clock cycles. A ratio of 0 or 1 gives a tick in every cycle.
- R3: A `presc_rst_i` strobe sampled at edge k clears the prescaler count. The ticks that follow land on edges k+P, k+2P and so on.
- R4: A trigger sampled at edge t loads the delay D and the width W. A tick at edge t is not counted. The level goes active at the (D+1)-th tick after edge t, so a delay of 0 gives the first tick after the trigger.
- R5: The level stays active for W ticks, which is W·P cycles, and then goes inactive. A trigger with W = 0 gives no pulse.
- R6: A trigger that arrives while a delay or width count is running is ignored. The pulse in progress keeps its original timing.
- R7: An enabled `set_i` without `clear_i` makes the level active from the next edge, with no delay. The level holds until a clear.
- R8: An enabled `clear_i` makes the level inactive from the next edge and aborts a running pulse. Clear wins over set and trigger in the same cycle.
- R9: `pulse_o` is the internal level XOR `cfg_polarity`. With polarity 1, the idle output is 1.
- R10: With `cfg_enable` = 0, trigger, set and clear have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | 1 = accept trigger, set and clear |
| cfg_polarity | input | 1 | 1 = invert the output pin |
| cfg_delay | input | DELAY_W | Delay, in prescaler ticks |
| cfg_width | input | WIDTH_W | Width, in prescaler ticks (0 = no pulse) |
| cfg_presc | input | PRESC_W | Prescaler ratio (0 or 1 = divide by 1) |
| presc_rst_i | input | 1 | Strobe that returns the prescaler to its initial phase |
| trig_i | input | 1 | Start strobe for the delay-width pulse |
| set_i | input | 1 | Force the level active |
| clear_i | input | 1 | Force the level inactive and abort any pulse |
| pulse_o | output | 1 | Generator output |

## Verification
A wrong prescaler phase or a wrong delay count shows up as a rising edge on `pulse_o` at the wrong cycle, whole ticks early or late. The monitor measures that edge against an edge number the bench works out after a phase-reset strobe. A wrong width count, or a state that reloads on a retrigger, moves the falling edge or adds extra edges. These appear within one pulse length. A wrong choice between set, clear and enable shows on the pin one cycle after the strobe, and the bench samples it there.

// File: rtl/dwpg_pkg.sv
package dwpg_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_DELAY = 2'd1,
    SEQ_WIDTH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/dwpg_prescaler.sv
module dwpg_prescaler #(
  parameter int PRESC_W   = 16,
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] div_i,
  input  logic               phase_rst_i,
  output logic               tick_o
);
  generate
    if (HAS_PRESC) begin : g_div
      localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);
      logic [PRESC_W-1:0] cnt_q;
      logic               bypass;
      logic               wrap;

      assign bypass = (div_i <= ONE);
      assign wrap   = (cnt_q >= div_i - ONE);
      assign tick_o = bypass | (wrap & ~phase_rst_i);

      always_ff @(posedge clk) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (phase_rst_i)         cnt_q <= '0;
        else if (bypass || wrap)      cnt_q <= '0;
        else                          cnt_q <= cnt_q + ONE;
      end
    end else begin : g_nodiv
      logic unused_nodiv;
      assign unused_nodiv = ^{div_i, phase_rst_i, clk, rst_n};
      assign tick_o = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/dwpg_sequencer.sv
module dwpg_sequencer
  import dwpg_pkg::*;
#(
  parameter int DELAY_W = 32,
  parameter int WIDTH_W = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick_i,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [DELAY_W-1:0] delay_i,
  input  logic [WIDTH_W-1:0] width_i,
  output logic               active_o,
  output logic               busy_o
);
  localparam logic [DELAY_W-1:0] D_ONE = DELAY_W'(1);
  localparam logic [WIDTH_W-1:0] W_ONE = WIDTH_W'(1);

  seq_state_e         state_q;
  logic [DELAY_W-1:0] dcnt_q;
  logic [WIDTH_W-1:0] wcnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      dcnt_q  <= '0;
      wcnt_q  <= '0;
    end else if (abort_i) begin
      state_q <= SEQ_IDLE;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start_i && (width_i != '0)) begin
            dcnt_q  <= delay_i;
            wcnt_q  <= width_i;
            state_q <= SEQ_DELAY;
          end
        end
        SEQ_DELAY: begin
          if (tick_i) begin
            if (dcnt_q == '0) state_q <= SEQ_WIDTH;
            else              dcnt_q  <= dcnt_q - D_ONE;
          end
        end
        SEQ_WIDTH: begin
          if (tick_i) begin
            if (wcnt_q == W_ONE) state_q <= SEQ_IDLE;
            else                 wcnt_q  <= wcnt_q - W_ONE;
          end
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign active_o = (state_q == SEQ_WIDTH);
  assign busy_o   = (state_q != SEQ_IDLE);
endmodule

// File: rtl/dwpg_force.sv
module dwpg_force (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic hold_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      hold_o <= 1'b0;
    else if (clr_i)  hold_o <= 1'b0;
    else if (set_i)  hold_o <= 1'b1;
  end
endmodule

// File: rtl/dly_wid_pulse_gen.sv
module dly_wid_pulse_gen #(
  parameter int DELAY_W   = 32,
  parameter int WIDTH_W   = 32,
  parameter int PRESC_W   = 16,
  parameter bit HAS_PRESC = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_enable,
  input  logic               cfg_polarity,
  input  logic [DELAY_W-1:0] cfg_delay,
  input  logic [WIDTH_W-1:0] cfg_width,
  input  logic [PRESC_W-1:0] cfg_presc,
  input  logic               presc_rst_i,
  input  logic               trig_i,
  input  logic               set_i,
  input  logic               clear_i,
  output logic               pulse_o
);
  logic tick;
  logic g_trig, g_set, g_clr;
  logic seq_active, seq_busy, hold;
  logic lvl;

  // Enable gates all three strobes; clear dominates set and trigger.
  assign g_clr  = cfg_enable & clear_i;
  assign g_set  = cfg_enable & set_i  & ~clear_i;
  assign g_trig = cfg_enable & trig_i & ~clear_i;

  dwpg_prescaler #(
    .PRESC_W  (PRESC_W),
    .HAS_PRESC(HAS_PRESC)
  ) u_presc (
    .clk        (clk),
    .rst_n      (rst_n),
    .div_i      (cfg_presc),
    .phase_rst_i(presc_rst_i),
    .tick_o     (tick)
  );

  dwpg_sequencer #(
    .DELAY_W(DELAY_W),
    .WIDTH_W(WIDTH_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .start_i (g_trig),
    .abort_i (g_clr),
    .delay_i (cfg_delay),
    .width_i (cfg_width),
    .active_o(seq_active),
    .busy_o  (seq_busy)
  );

  dwpg_force u_force (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (g_set),
    .clr_i (g_clr),
    .hold_o(hold)
  );

  assign lvl     = seq_active | hold;
  assign pulse_o = lvl ^ cfg_polarity;
endmodule

// File: rtl/dwpg_chk.sv
module dwpg_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic clear_i,
  input logic set_i,
  input logic tick,
  input logic seq_active,
  input logic seq_busy,
  input logic hold,
  input logic lvl
);
  // R4
  delay_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_active) |-> $past(tick));

  // R5
  width_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_active) |-> ($past(tick) || $past(clear_i && cfg_enable)));

  // R7
  set_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clear_i && cfg_enable) |=> lvl);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_i && cfg_enable) |=> !lvl);

  // R10
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_enable && !seq_busy && !hold) |=> !lvl);
endmodule

bind dly_wid_pulse_gen dwpg_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_enable(cfg_enable),
  .clear_i   (clear_i),
  .set_i     (set_i),
  .tick      (tick),
  .seq_active(seq_active),
  .seq_busy  (seq_busy),
  .hold      (hold),
  .lvl       (lvl)
);

// File: tb/dly_wid_pulse_gen_tb.sv
module dly_wid_pulse_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_enable = 1'b0, cfg_polarity = 1'b0;
  logic [31:0] cfg_delay = '0, cfg_width = '0;
  logic [15:0] cfg_presc = '0;
  logic        presc_rst_i = 1'b0, trig_i = 1'b0, set_i = 1'b0, clear_i = 1'b0;
  logic        pulse_o;

  int cyc = 0;
  int n_cmp = 0, n_bad = 0;
  int exp_rise_q[$], exp_fall_q[$];
  bit mon_en = 1'b0;
  bit prev_lvl = 1'b0;
  int seen_rise = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dly_wid_pulse_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_polarity(cfg_polarity),
    .cfg_delay(cfg_delay), .cfg_width(cfg_width), .cfg_presc(cfg_presc),
    .presc_rst_i(presc_rst_i), .trig_i(trig_i), .set_i(set_i), .clear_i(clear_i),
    .pulse_o(pulse_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: edges of the polarity-corrected level, compared with the scoreboard.
  always @(negedge clk) begin
    bit l;
    l = pulse_o ^ cfg_polarity;
    if (mon_en && rst_n) begin
      if (l && !prev_lvl) seen_rise = cyc;
      if (!l && prev_lvl) begin
        if (exp_rise_q.size() == 0) begin
          check(1'b0, "R6 unexpected pulse", cyc, -1);
        end else begin
          int er, ef;
          er = exp_rise_q.pop_front();
          ef = exp_fall_q.pop_front();
          check(seen_rise == er, "R4 rise edge", seen_rise, er);
          check(cyc == ef, "R5 fall edge", cyc, ef);
        end
      end
    end
    prev_lvl = l;
  end

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // Driver: phase reset, trigger, and push of the expected edges (R2, R3, R4, R5).
  task automatic run_pulse(input int p, input int dl, input int w, input int off, input bit retrig);
    int k, t, n, m1, rise, fall;
    cfg_presc = 16'(p); cfg_delay = dl; cfg_width = w;
    @(negedge clk); presc_rst_i = 1'b1; k = cyc + 1;
    @(negedge clk); presc_rst_i = 1'b0;
    repeat (off) @(negedge clk);
    trig_i = 1'b1; t = cyc + 1;
    @(negedge clk); trig_i = 1'b0;
    n = 1;
    while (k + n * p <= t) n++;
    m1   = k + n * p;
    rise = m1 + dl * p;
    fall = rise + w * p;
    if (w != 0) begin
      exp_rise_q.push_back(rise);
      exp_fall_q.push_back(fall);
    end
    if (retrig) begin
      // R6: retrigger once in the delay phase and once in the width phase
      trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
      while (cyc < rise + 1) @(negedge clk);
      trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    end
    while (cyc < fall + 3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(pulse_o == 1'b0, "R1 reset output", pulse_o, 0);
    cfg_enable = 1'b1;
    mon_en = 1'b1;

    run_pulse(4, 2, 3, 1, 1'b0);   // R2 R3 R4 R5
    run_pulse(1, 0, 1, 2, 1'b0);   // R2 divide by one
    run_pulse(3, 0, 2, 2, 1'b0);   // R4 trigger on a tick edge
    run_pulse(5, 1, 2, 3, 1'b0);
    run_pulse(2, 1, 3, 1, 1'b1);   // R6 retriggers ignored
    run_pulse(2, 1, 0, 1, 1'b0);   // R5 zero width
    check((pulse_o ^ cfg_polarity) == 1'b0, "R5 zero width stays idle", pulse_o, 0);
    check(exp_rise_q.size() == 0, "R6 scoreboard drained", exp_rise_q.size(), 0);

    // R9: inverted polarity
    cfg_polarity = 1'b1;
    @(negedge clk);
    check(pulse_o == 1'b1, "R9 idle inverted", pulse_o, 1);
    run_pulse(3, 1, 2, 1, 1'b0);
    check(exp_rise_q.size() == 0, "R9 inverted pulse seen", exp_rise_q.size(), 0);
    cfg_polarity = 1'b0;
    mon_en = 1'b0;

    // R7 set, R8 clear
    @(negedge clk); set_i = 1'b1; @(negedge clk); set_i = 1'b0;
    check(pulse_o == 1'b1, "R7 set immediate", pulse_o, 1);
    repeat (5) @(negedge clk);
    check(pulse_o == 1'b1, "R7 set holds", pulse_o, 1);
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(pulse_o == 1'b0, "R8 clear", pulse_o, 0);
    set_i = 1'b1; clear_i = 1'b1; @(negedge clk); set_i = 1'b0; clear_i = 1'b0;
    check(pulse_o == 1'b0, "R8 clear wins over set", pulse_o, 0);

    // R8: clear aborts a running pulse; trigger with clear is dropped
    cfg_presc = 16'd1; cfg_delay = 0; cfg_width = 20;
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse_o == 1'b1, "R4 pulse running before abort", pulse_o, 1);
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(pulse_o == 1'b0, "R8 abort", pulse_o, 0);
    repeat (25) @(negedge clk);
    check(pulse_o == 1'b0, "R8 abort stays idle", pulse_o, 0);
    trig_i = 1'b1; clear_i = 1'b1; @(negedge clk); trig_i = 1'b0; clear_i = 1'b0;
    repeat (4) @(negedge clk);
    check(pulse_o == 1'b0, "R8 clear wins over trigger", pulse_o, 0);

    // R10: disabled inputs
    cfg_enable = 1'b0;
    trig_i = 1'b1; @(negedge clk); trig_i = 1'b0;
    repeat (4) @(negedge clk);
    check(pulse_o == 1'b0, "R10 trigger ignored", pulse_o, 0);
    set_i = 1'b1; @(negedge clk); set_i = 1'b0;
    check(pulse_o == 1'b0, "R10 set ignored", pulse_o, 0);
    cfg_enable = 1'b1;
    set_i = 1'b1; @(negedge clk); set_i = 1'b0;
    cfg_enable = 1'b0;
    clear_i = 1'b1; @(negedge clk); clear_i = 1'b0;
    check(pulse_o == 1'b1, "R10 clear ignored", pulse_o, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule